// File: doc/BRIEF.md
# Register-Programmed SPI Shift Master

This block is an SPI master run from a small 32-bit register port. Software does not toggle the bus pins. It loads the transmit word and the clock divider, then writes one command word. The hardware shifts between 1 and 32 bits at a time, with the most significant bit of each byte first. It drives the serial clock and the output data line, samples the input data line, and leaves the received bits in a read-only register. The start bit of the command reads as 1 for as long as the shift runs. Software polls that bit to find out when the shift is over.

Each command picks one of three active-low chip selects. It also carries an end flag. With the flag set, the select is released a half clock period after the last bit. With the flag clear, the select stays low, so the next command continues the same bus transaction. Longer frames are built this way from 32-bit pieces. The bus runs in SPI mode 0: the clock idles low, output data changes while the clock is low, and input data is sampled on the rising edge.

Top module: `spi_shift_master`

## Requirements
- R1: After reset, all chip selects are high and `sck` and `mosi` are low. Every register reads as zero.
- R2: The register at byte offset 0x04 holds the divider N in bits [5:0]. Each high phase and each low phase of `sck` inside a shift lasts N+1 clock cycles. `sck` is low whenever no shift is running.
- R3: A command of n bits produces exactly n rising edges of `sck`. The transmit register (offset 0x10) is sent from bit n-1 down to bit 0. `mosi` changes only while `sck` is low.
- R4: The receive register (offset 0x18) holds the n bits sampled on the rising edges, the last one in bit 0, with zeros above bit n-1. It changes only in the cycle in which a shift completes.
- R5: The command register is at offset 0x14. Bit 31 starts a shift and reads 1 while the shift runs. Bits [30:28] select the chip selects, bit 26 is the end flag, and bits [5:0] are the bit count. While the shift runs, the register reads back the accepted command with bit 31 set. Bit 31 clears when the shift completes.
- R6: While a command runs, `cs_n[i]` is low exactly for each set bit 28+i of the command, and every other select is high.
- R7: With the end flag at 1, all selects go high N+1 cycles after the last falling edge of `sck`. With the end flag at 0, the selected line stays low after completion, through the next command on the same line.
- R8: At least N+1 cycles separate a chip select going low from the first rising edge of `sck`. The first low phase of a command lasts exactly N+1 cycles.
- R9: A command write is ignored while a shift runs. A command write is also ignored when its count is 0 or greater than 32.
- R10: Bit 0 at offset 0x00 enables the block. While it is 0, all selects are high and command writes are ignored. Clearing it during a shift aborts the shift and leaves the receive register unchanged.
- R11: The enable bit, the divider (bits [5:0] only) and the transmit register read back what was written. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 3 | Active-low chip selects |

## Verification
The awkward collision is a command write that lands in the very cycle in which the running shift completes. At that edge the start bit still reads 1, so the write must be ignored, even though the start bit reads 0 in the next cycle. The bench provokes this by holding the write strobe on the command register with a different command, every cycle, until the start bit reads 0. It then checks three things: the bit count of the first command was kept, no second shift started, and the chip selects follow the first command's end flag. A second overlap is an enable clear in the middle of a shift. The bench checks that this releases the selects and clears the start bit without touching the receive register.

// File: rtl/spi_shift_pkg.sv
package spi_shift_pkg;
    localparam int unsigned REG_W  = 32;
    localparam int unsigned ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_FUNC  = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_TXD   = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_SHIFT = 5'h14;
    localparam logic [ADDR_W-1:0] OFS_RXD   = 5'h18;

    localparam int unsigned START_BIT = 31;
    localparam int unsigned CS_LSB    = 28;
    localparam int unsigned TERM_BIT  = 26;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2,
        PH_TAIL = 2'd3
    } phase_e;
endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
    parameter int unsigned DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] lim,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == lim);
        cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_shift_pkg::*;
#(
    parameter int unsigned MAX_BITS = 32,
    parameter int unsigned DIV_W    = 6,
    parameter int unsigned CS_NUM   = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          enable,
    input  logic                          start,
    input  logic [CS_NUM-1:0]             sel,
    input  logic                          term,
    input  logic [$clog2(MAX_BITS):0]     nbits,
    input  logic [MAX_BITS-1:0]           txd,
    input  logic [DIV_W-1:0]              div,
    input  logic                          miso,
    output logic                          busy,
    output logic                          done,
    output logic [MAX_BITS-1:0]           rxd,
    output logic                          sck,
    output logic                          mosi,
    output logic [CS_NUM-1:0]             cs_n
);
    localparam int unsigned CNT_W = $clog2(MAX_BITS) + 1;

    typedef struct packed {
        phase_e              phase;
        logic [DIV_W-1:0]    lim;
        logic [CNT_W-1:0]    left;
        logic [MAX_BITS-1:0] tx_sr;
        logic [MAX_BITS-1:0] rx_sr;
        logic                sck;
        logic                mosi;
        logic                term;
        logic [CS_NUM-1:0]   cs_act;
    } eng_s;

    eng_s st_d, st_q;
    logic tick;
    logic [CNT_W-1:0]    align_sh;
    logic [MAX_BITS-1:0] aligned;

    spi_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (st_q.phase != PH_IDLE),
        .lim  (st_q.lim),
        .tick (tick)
    );

    always_comb begin
        st_d     = st_q;
        done     = 1'b0;
        align_sh = CNT_W'(MAX_BITS) - nbits;
        aligned  = txd << align_sh;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase  = PH_LOW;
                    st_d.lim    = div;
                    st_d.left   = nbits;
                    st_d.tx_sr  = aligned;
                    st_d.mosi   = aligned[MAX_BITS-1];
                    st_d.rx_sr  = '0;
                    st_d.sck    = 1'b0;
                    st_d.term   = term;
                    st_d.cs_act = sel;
                end
            end
            PH_LOW: begin
                if (tick) begin
                    st_d.sck   = 1'b1;
                    st_d.rx_sr = {st_q.rx_sr[MAX_BITS-2:0], miso};
                    st_d.left  = st_q.left - 1'b1;
                    st_d.phase = PH_HIGH;
                end
            end
            PH_HIGH: begin
                if (tick) begin
                    st_d.sck = 1'b0;
                    if (st_q.left == '0) begin
                        if (st_q.term) begin
                            st_d.phase = PH_TAIL;
                        end else begin
                            st_d.phase = PH_IDLE;
                            done       = 1'b1;
                        end
                    end else begin
                        st_d.tx_sr = st_q.tx_sr << 1;
                        st_d.mosi  = st_q.tx_sr[MAX_BITS-2];
                        st_d.phase = PH_LOW;
                    end
                end
            end
            PH_TAIL: begin
                if (tick) begin
                    st_d.cs_act = '0;
                    st_d.phase  = PH_IDLE;
                    done        = 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
        if (!enable) begin
            st_d.phase  = PH_IDLE;
            st_d.sck    = 1'b0;
            st_d.mosi   = 1'b0;
            st_d.cs_act = '0;
            done        = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = (st_q.phase != PH_IDLE);
    assign rxd  = st_q.rx_sr;
    assign sck  = st_q.sck;
    assign mosi = st_q.mosi;
    assign cs_n = ~st_q.cs_act;
endmodule

// File: rtl/spi_shift_master.sv
module spi_shift_master
    import spi_shift_pkg::*;
#(
    parameter int unsigned MAX_BITS = 32,
    parameter int unsigned DIV_W    = 6,
    parameter int unsigned CS_NUM   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [CS_NUM-1:0] cs_n
);
    localparam int unsigned CNT_W = $clog2(MAX_BITS) + 1;

    typedef struct packed {
        logic                en;
        logic [DIV_W-1:0]    div;
        logic [MAX_BITS-1:0] txd;
        logic [CS_NUM-1:0]   sel;
        logic                term;
        logic [CNT_W-1:0]    nbits;
        logic [MAX_BITS-1:0] rxd;
    } regs_s;

    regs_s regs_d, regs_q;
    logic                eng_busy, eng_done, launch;
    logic [MAX_BITS-1:0] eng_rxd;
    logic [CNT_W-1:0]    cmd_bits;
    logic                en_q;
    logic [MAX_BITS-1:0] rxd_q;

    assign en_q     = regs_q.en;
    assign rxd_q    = regs_q.rxd;
    assign cmd_bits = bus_wdata[CNT_W-1:0];

    always_comb begin
        regs_d = regs_q;
        launch = bus_wr && (bus_addr == OFS_SHIFT) && bus_wdata[START_BIT]
                 && regs_q.en && !eng_busy
                 && (cmd_bits != '0) && (cmd_bits <= CNT_W'(MAX_BITS));
        if (bus_wr) begin
            unique case (bus_addr)
                OFS_FUNC: regs_d.en  = bus_wdata[0];
                OFS_CTRL: regs_d.div = bus_wdata[DIV_W-1:0];
                OFS_TXD:  regs_d.txd = bus_wdata[MAX_BITS-1:0];
                default: ;
            endcase
        end
        if (launch) begin
            regs_d.sel   = bus_wdata[CS_LSB +: CS_NUM];
            regs_d.term  = bus_wdata[TERM_BIT];
            regs_d.nbits = cmd_bits;
        end
        if (eng_done) regs_d.rxd = eng_rxd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_FUNC: bus_rdata[0] = regs_q.en;
            OFS_CTRL: bus_rdata[DIV_W-1:0] = regs_q.div;
            OFS_TXD:  bus_rdata[MAX_BITS-1:0] = regs_q.txd;
            OFS_SHIFT: begin
                bus_rdata[START_BIT]           = eng_busy;
                bus_rdata[CS_LSB +: CS_NUM]    = regs_q.sel;
                bus_rdata[TERM_BIT]            = regs_q.term;
                bus_rdata[CNT_W-1:0]           = regs_q.nbits;
            end
            OFS_RXD:  bus_rdata[MAX_BITS-1:0] = regs_q.rxd;
            default: ;
        endcase
    end

    spi_shift_engine #(
        .MAX_BITS(MAX_BITS),
        .DIV_W   (DIV_W),
        .CS_NUM  (CS_NUM)
    ) u_engine (
        .clk   (clk),
        .rst_n (rst_n),
        .enable(en_q),
        .start (launch),
        .sel   (bus_wdata[CS_LSB +: CS_NUM]),
        .term  (bus_wdata[TERM_BIT]),
        .nbits (cmd_bits),
        .txd   (regs_q.txd),
        .div   (regs_q.div),
        .miso  (miso),
        .busy  (eng_busy),
        .done  (eng_done),
        .rxd   (eng_rxd),
        .sck   (sck),
        .mosi  (mosi),
        .cs_n  (cs_n)
    );
endmodule

// File: rtl/spi_shift_master_chk.sv
module spi_shift_master_chk #(
    parameter int unsigned MAX_BITS = 32,
    parameter int unsigned CS_NUM   = 3,
    parameter int unsigned CNT_W    = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                en,
    input logic                busy,
    input logic                sck,
    input logic                mosi,
    input logic [CS_NUM-1:0]   cs_n,
    input logic [MAX_BITS-1:0] rxd,
    input logic                wr,
    input logic [4:0]          addr,
    input logic                start_bit,
    input logic [CNT_W-1:0]    cnt_field
);
    AST_DISABLE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (&cs_n)); // R10
    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck); // R2
    AST_MOSI_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$stable(mosi)) |-> !sck); // R3
    AST_RXD_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rxd) |-> $fell(busy)); // R4
    AST_ZERO_COUNT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == 5'h14 && start_bit && cnt_field == '0 && !busy) |=> !busy); // R9
    AST_SELECT_BEFORE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~cs_n & $past(cs_n))) |-> !sck); // R8
endmodule

bind spi_shift_master spi_shift_master_chk #(
    .MAX_BITS(MAX_BITS),
    .CS_NUM  (CS_NUM),
    .CNT_W   (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en_q),
    .busy     (eng_busy),
    .sck      (sck),
    .mosi     (mosi),
    .cs_n     (cs_n),
    .rxd      (rxd_q),
    .wr       (bus_wr),
    .addr     (bus_addr),
    .start_bit(bus_wdata[31]),
    .cnt_field(bus_wdata[CNT_W-1:0])
);

// File: tb/spi_shift_master_test.sv
module spi_shift_master_test;
    localparam logic [4:0] A_FUNC = 5'h00, A_CTRL = 5'h04, A_TXD = 5'h10,
                           A_SHIFT = 5'h14, A_RXD = 5'h18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sck, mosi, miso;
    logic [2:0]  cs_n;
    logic        inv = 1'b0;

    int errors = 0, checks = 0;
    bit finished = 0;
    int cyc = 0, seg_start = 0, rise_at = 0, fall_at = 0;
    int rises = 0, mon_err = 0, cs_rel = 0, cur_div = 0;
    logic [31:0] tx_bits = '0;
    logic p_sck = 1'b0;
    logic [2:0] p_cs = 3'b111;

    assign miso = mosi ^ inv;

    always #5 clk = ~clk;

    spi_shift_master uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck(sck),
        .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!p_sck && sck) begin
                rises = rises + 1;
                tx_bits = {tx_bits[30:0], mosi};
                if (cyc - seg_start != cur_div + 1) mon_err = mon_err + 1;
                rise_at = cyc;
            end
            if (p_sck && !sck) begin
                if (cyc - rise_at != cur_div + 1) mon_err = mon_err + 1;
                seg_start = cyc;
                fall_at = cyc;
            end
            if ((cs_n & ~p_cs) != 3'b000) cs_rel = cs_rel + 1;
            if (cs_n == 3'b111 && p_cs != 3'b111 && cyc - fall_at != cur_div + 1)
                mon_err = mon_err + 1;
            p_sck = sck;
            p_cs = cs_n;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [31:0] cmd_word(input int n, input int cs, input bit term);
        return 32'h8000_0000 | (32'd1 << (28 + cs)) | (term ? 32'h0400_0000 : 32'h0)
               | 32'(n);
    endfunction

    task automatic wait_idle();
        bus_addr = A_SHIFT;
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            #1;
            if (!bus_rdata[31]) break;
        end
    endtask

    task automatic run_cmd(input int n, input int cs, input bit term,
                           input logic [31:0] data, input int dv);
        logic [31:0] ctl, mask, v, exp_rx;
        mask = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1);
        exp_rx = (data ^ {32{inv}}) & mask;
        cur_div = dv;
        bus_write(A_CTRL, 32'(dv));
        bus_write(A_TXD, data);
        rises = 0; tx_bits = '0; mon_err = 0;
        ctl = cmd_word(n, cs, term);
        bus_write(A_SHIFT, ctl);
        seg_start = cyc;
        bus_addr = A_SHIFT;
        #1;
        chk(cs_n == ~(3'b001 << cs), "R6 select during shift", 32'(cs_n), 32'(~(3'b001 << cs)));
        chk(bus_rdata == ctl, "R5 command readback while busy", bus_rdata, ctl);
        wait_idle();
        chk(bus_rdata[31] == 1'b0, "R5 start bit cleared", bus_rdata, 32'h0);
        chk(rises == n, "R3 rising edge count", 32'(rises), 32'(n));
        chk(tx_bits == (data & mask), "R3 transmit order", tx_bits, data & mask);
        chk(mon_err == 0, "R2 R8 half period and gaps", 32'(mon_err), 32'h0);
        bus_read(A_RXD, v);
        chk(v == exp_rx, "R4 receive data", v, exp_rx);
        if (term) chk(cs_n == 3'b111, "R7 release after end flag", 32'(cs_n), 32'h7);
        else      chk(cs_n == ~(3'b001 << cs), "R7 hold without end flag",
                      32'(cs_n), 32'(~(3'b001 << cs)));
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, saved;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(cs_n == 3'b111, "R1 selects high", 32'(cs_n), 32'h7);
        chk(sck == 1'b0 && mosi == 1'b0, "R1 sck mosi low", {30'h0, sck, mosi}, 32'h0);
        bus_read(A_FUNC, v);  chk(v == 0, "R1 enable reg", v, 0);
        bus_read(A_CTRL, v);  chk(v == 0, "R1 divider reg", v, 0);
        bus_read(A_TXD, v);   chk(v == 0, "R1 transmit reg", v, 0);
        bus_read(A_SHIFT, v); chk(v == 0, "R1 command reg", v, 0);
        bus_read(A_RXD, v);   chk(v == 0, "R1 receive reg", v, 0);

        // R10 command while disabled
        bus_write(A_SHIFT, cmd_word(8, 0, 1'b1));
        bus_read(A_SHIFT, v);
        chk(v[31] == 1'b0 && cs_n == 3'b111, "R10 launch while disabled", v, 0);

        // R11 readback
        bus_write(A_FUNC, 32'h1);
        bus_read(A_FUNC, v);  chk(v == 32'h1, "R11 enable readback", v, 32'h1);
        bus_write(A_CTRL, 32'hFFFF_FFEA);
        bus_read(A_CTRL, v);  chk(v == 32'h2A, "R11 divider width", v, 32'h2A);
        bus_write(A_TXD, 32'hC0DE_5EED);
        bus_read(A_TXD, v);   chk(v == 32'hC0DE_5EED, "R11 transmit readback", v, 32'hC0DE_5EED);
        bus_read(5'h08, v);   chk(v == 0, "R11 unmapped offset", v, 0);

        // R9 zero and oversize counts
        rises = 0;
        bus_write(A_SHIFT, 32'h8000_0000 | (32'd1 << 28));
        bus_read(A_SHIFT, v);
        chk(v[31] == 1'b0 && cs_n == 3'b111, "R9 zero count ignored", v, 0);
        bus_write(A_SHIFT, 32'h8400_0000 | (32'd1 << 29) | 32'd40);
        repeat (4) @(negedge clk);
        #1 chk(rises == 0 && cs_n == 3'b111, "R9 oversize count ignored", 32'(rises), 0);

        // Sweep: every count, three dividers, rotating selects and end flags
        for (int d = 0; d < 3; d++) begin
            for (int n = 1; n <= 32; n++) begin
                inv = n[0];
                run_cmd(n, n % 3, (n % 4) != 1,
                        32'h9E37_79B9 * 32'(n + 40 * d) + 32'h1357_9BDF,
                        (d == 2) ? 3 : d);
            end
        end

        // R7 select held across two commands on one line
        inv = 1'b0;
        run_cmd(8, 1, 1'b1, 32'h0000_00A5, 1);
        cs_rel = 0;
        run_cmd(16, 1, 1'b0, 32'h0000_3C5A, 1);
        run_cmd(8, 1, 1'b1, 32'h0000_0081, 1);
        chk(cs_rel == 1, "R7 single release across joined commands", 32'(cs_rel), 32'h1);

        // R9 collision: command writes every cycle until completion
        cur_div = 1;
        bus_write(A_CTRL, 32'h1);
        bus_write(A_TXD, 32'h0000_00C3);
        rises = 0;
        @(negedge clk);
        bus_addr = A_SHIFT; bus_wdata = cmd_word(8, 2, 1'b1); bus_wr = 1'b1;
        @(negedge clk);
        bus_wdata = cmd_word(16, 0, 1'b0);
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            if (!bus_rdata[31]) break;
        end
        bus_wr = 1'b0;
        repeat (10) @(negedge clk);
        #1;
        chk(rises == 8, "R9 writes while busy ignored", 32'(rises), 32'h8);
        chk(cs_n == 3'b111, "R9 first command end flag kept", 32'(cs_n), 32'h7);
        bus_read(A_SHIFT, v);
        chk(v[31] == 1'b0 && v[5:0] == 6'd8, "R9 no second shift", v, 32'h8);

        // R10 abort by clearing enable
        bus_read(A_RXD, saved);
        bus_write(A_CTRL, 32'h3);
        bus_write(A_TXD, 32'hFFFF_0000);
        bus_write(A_SHIFT, cmd_word(32, 0, 1'b1));
        repeat (20) @(negedge clk);
        bus_write(A_FUNC, 32'h0);
        @(negedge clk);
        #1 chk(cs_n == 3'b111 && sck == 1'b0, "R10 abort releases select",
               {28'h0, sck, cs_n}, 32'h7);
        bus_read(A_SHIFT, v);
        chk(v[31] == 1'b0, "R10 abort clears start bit", v, 0);
        bus_read(A_RXD, v);
        chk(v == saved, "R10 receive unchanged on abort", v, saved);
        bus_write(A_FUNC, 32'h1);
        inv = 1'b1;
        run_cmd(24, 2, 1'b1, 32'h00AB_CDEF, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule